// File: doc/BRIEF.md
# BCD Calendar Clock with Full-Match Alarm

This block keeps wall-clock time and date as packed BCD bytes: seconds, minutes, hours (24-hour), day of month, month, two-digit year, plus a day-of-week counter. A free-running stream of single-cycle tick pulses, nominally at 32768 Hz, feeds a prescaler. Each time the prescaler completes a full second of ticks, the calendar moves forward by one second. Carries ripple through minutes, hours, days, months and years. Month lengths are honoured, and a year value divisible by four is a leap year, which covers 2000 to 2099.

Software reaches the clock through a byte-wide register port with a combinational read. It can set any time field, program an alarm date and time, start or freeze counting, and poll a status byte. The alarm triggers only when all six date and time fields match; no field can be ignored. The status byte carries sticky event flags for second, minute, hour and day boundaries and for the alarm. Software clears them by writing ones. A busy bit marks the final prescaler count before an update, so software can avoid reading a time that is about to change. A single interrupt output combines the enabled flags.

Top module: `bcd_cal_clock`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0. The control, status and interrupt-enable registers read 0x00 and `irq` is low.
- R2: Register offsets are: seconds 0x00, minutes 0x04, hours 0x08, day 0x0C, month 0x10, year 0x14, weekday 0x18, and alarm fields at the same order from 0x20 to 0x34. Control is 0x44-4=0x40, status is 0x44 and interrupt enable is 0x48. While running, the time advances by one second on every PRESCALE-th counted tick. Status bit 0 (busy) is high during the last prescaler count before that update and low once the update has happened.
- R3: Seconds and minutes wrap from 0x59 to 0x00, hours from 0x23 to 0x00, month from 0x12 to 0x01 and year from 0x99 to 0x00, each carrying into the next field.
- R4: The day wraps to 0x01 after 0x30 in months 4, 6, 9 and 11, and after 0x31 in the other months. In month 2 it wraps after 0x29 when the year is divisible by four and after 0x28 otherwise.
- R5: The weekday register advances by one on every day change and wraps from 6 to 0.
- R6: A write to any time field takes effect at once and restarts the prescaler. The next update therefore comes exactly PRESCALE counted ticks after the write.
- R7: Status bit 6 (alarm) sets on the update whose new seconds, minutes, hours, day, month and year all equal the alarm fields. A difference in any single field prevents it.
- R8: On each update, status bit 2 sets. Bit 3 also sets when the minute changes, bit 4 when the hour changes and bit 5 when the day changes. Writing 1 to any of bits 2 to 6 clears that bit, and writing 0 leaves it unchanged.
- R9: `irq` is high exactly when the alarm flag is set with interrupt-enable bit 3, or the second flag (status bit 2) is set with interrupt-enable bit 2.
- R10: Control bit 0 runs the clock; with it clear, the time holds still. Status bit 1 reports the run state.
- R11: Cycles with `tick` low are not counted by the prescaler and never advance the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per 32 kHz period |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Combined enabled-flag interrupt |

## Verification
The bench targets the carry boundaries: 23:59:59 on the last day of a 30-day month, of a 31-day month, of February in leap and common years, and of 99-12-31. A design with a wrong month table or leap rule lands on a non-existent day or skips 29 February, and a broken carry chain leaves a stale minute or year. The alarm is placed on the next second with one field nudged at a time, so a comparator that skips a field fires falsely. A prescaler that is not restarted by a write shows the update on the wrong cycle relative to busy. Gated ticks and a stopped clock expose a counter that advances without permission.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    typedef struct packed {
        logic [7:0] wday;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] second;
    } cal_time_t;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] second;
    } cal_alarm_t;

    localparam int ALARM_FIELDS = 6;

    // register offsets; software decodes these
    localparam logic [7:0] OFS_SEC   = 8'h00;
    localparam logic [7:0] OFS_MIN   = 8'h04;
    localparam logic [7:0] OFS_HOUR  = 8'h08;
    localparam logic [7:0] OFS_DAY   = 8'h0C;
    localparam logic [7:0] OFS_MON   = 8'h10;
    localparam logic [7:0] OFS_YEAR  = 8'h14;
    localparam logic [7:0] OFS_WDAY  = 8'h18;
    localparam logic [7:0] ALM_SEC   = 8'h20;
    localparam logic [7:0] ALM_MIN   = 8'h24;
    localparam logic [7:0] ALM_HOUR  = 8'h28;
    localparam logic [7:0] ALM_DAY   = 8'h2C;
    localparam logic [7:0] ALM_MON   = 8'h30;
    localparam logic [7:0] ALM_YEAR  = 8'h34;
    localparam logic [7:0] OFS_CTRL  = 8'h40;
    localparam logic [7:0] OFS_STAT  = 8'h44;
    localparam logic [7:0] OFS_IEN   = 8'h48;

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    endfunction

    // {carry, next}: wraps to 'bottom' after 'top'
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] top,
                                            input logic [7:0] bottom);
        if (v == top)
            return {1'b1, bottom};
        else if (v[3:0] == 4'h9)
            return {1'b0, v[7:4] + 4'h1, 4'h0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'h1};
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mon,
                                            input logic [7:0] yr);
        logic [7:0] ybin;
        ybin = bcd_to_bin(yr);
        case (mon)
            8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic restart,
    output logic step,
    output logic busy
);
    localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = '0;
        else if (enable && tick)
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = enable && (cnt_q == LAST);
    assign step = busy && tick && !restart;

endmodule

// File: rtl/cal_bcd_advance.sv
module cal_bcd_advance
    import bcd_cal_pkg::*;
(
    input  cal_time_t  now,
    output cal_time_t  next,
    output logic [3:0] events   // [0] second [1] minute [2] hour [3] day
);
    logic c_sec, c_min, c_hour, c_day, c_mon, c_year;
    logic [7:0] dmax;

    always_comb begin
        next   = now;
        events = 4'b0001;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        dmax   = last_day(now.month, now.year);

        {c_sec, next.second} = bcd_step(now.second, 8'h59, 8'h00);
        if (c_sec) begin
            events[1] = 1'b1;
            {c_min, next.minute} = bcd_step(now.minute, 8'h59, 8'h00);
        end
        if (c_min) begin
            events[2] = 1'b1;
            {c_hour, next.hour} = bcd_step(now.hour, 8'h23, 8'h00);
        end
        if (c_hour) begin
            events[3] = 1'b1;
            {c_day, next.day} = bcd_step(now.day, dmax, 8'h01);
            next.wday = (now.wday >= 8'h06) ? 8'h00 : now.wday + 8'h01;
        end
        if (c_day)
            {c_mon, next.month} = bcd_step(now.month, 8'h12, 8'h01);
        if (c_mon)
            {c_year, next.year} = bcd_step(now.year, 8'h99, 8'h00);
    end

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp #(
    parameter int FIELDS = 6
) (
    input  logic [8*FIELDS-1:0] lhs,
    input  logic [8*FIELDS-1:0] rhs,
    output logic                hit
);
    logic [FIELDS-1:0] eq;

    for (genvar i = 0; i < FIELDS; i++) begin : g_field
        assign eq[i] = (lhs[8*i +: 8] == rhs[8*i +: 8]);
    end

    assign hit = &eq;

endmodule

// File: rtl/bcd_cal_clock.sv
module bcd_cal_clock
    import bcd_cal_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       bus_en,
    input  logic       bus_we,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    typedef struct packed {
        cal_time_t  now;
        cal_alarm_t alm;
        logic       run;
        logic [4:0] ev;       // [0] sec [1] min [2] hour [3] day [4] alarm
        logic       ie_timer;
        logic       ie_alarm;
    } state_t;

    localparam cal_time_t  TIME_RST  = '{wday: 8'h00, year: 8'h00, month: 8'h01,
                                        day: 8'h01, hour: 8'h00, minute: 8'h00,
                                        second: 8'h00};
    localparam cal_alarm_t ALARM_RST = '{year: 8'h00, month: 8'h01, day: 8'h01,
                                        hour: 8'h00, minute: 8'h00, second: 8'h00};

    state_t     s_d, s_q;
    logic       wr, time_wr, step, busy, alarm_hit;
    cal_time_t  adv_next;
    logic [3:0] adv_ev;
    cal_alarm_t next_fields;

    assign wr      = bus_en && bus_we;
    assign time_wr = wr && (bus_addr inside {OFS_SEC, OFS_MIN, OFS_HOUR, OFS_DAY,
                                             OFS_MON, OFS_YEAR, OFS_WDAY});

    cal_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (s_q.run),
        .tick    (tick),
        .restart (time_wr),
        .step    (step),
        .busy    (busy)
    );

    cal_bcd_advance u_adv (
        .now    (s_q.now),
        .next   (adv_next),
        .events (adv_ev)
    );

    assign next_fields = '{year: adv_next.year, month: adv_next.month,
                           day: adv_next.day, hour: adv_next.hour,
                           minute: adv_next.minute, second: adv_next.second};

    cal_alarm_cmp #(.FIELDS(ALARM_FIELDS)) u_cmp (
        .lhs (next_fields),
        .rhs (s_q.alm),
        .hit (alarm_hit)
    );

    always_comb begin
        s_d = s_q;
        if (wr) begin
            case (bus_addr)
                OFS_SEC:  s_d.now.second = bus_wdata;
                OFS_MIN:  s_d.now.minute = bus_wdata;
                OFS_HOUR: s_d.now.hour   = bus_wdata;
                OFS_DAY:  s_d.now.day    = bus_wdata;
                OFS_MON:  s_d.now.month  = bus_wdata;
                OFS_YEAR: s_d.now.year   = bus_wdata;
                OFS_WDAY: s_d.now.wday   = bus_wdata;
                ALM_SEC:  s_d.alm.second = bus_wdata;
                ALM_MIN:  s_d.alm.minute = bus_wdata;
                ALM_HOUR: s_d.alm.hour   = bus_wdata;
                ALM_DAY:  s_d.alm.day    = bus_wdata;
                ALM_MON:  s_d.alm.month  = bus_wdata;
                ALM_YEAR: s_d.alm.year   = bus_wdata;
                OFS_CTRL: s_d.run        = bus_wdata[0];
                OFS_STAT: s_d.ev         = s_q.ev & ~bus_wdata[6:2];
                OFS_IEN: begin
                    s_d.ie_timer = bus_wdata[2];
                    s_d.ie_alarm = bus_wdata[3];
                end
                default: ;
            endcase
        end
        // a flag raised by an update wins over a clear in the same cycle
        if (step) begin
            s_d.now = adv_next;
            s_d.ev  = s_d.ev | {alarm_hit, adv_ev};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.now      <= TIME_RST;
            s_q.alm      <= ALARM_RST;
            s_q.run      <= 1'b0;
            s_q.ev       <= '0;
            s_q.ie_timer <= 1'b0;
            s_q.ie_alarm <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_SEC:  bus_rdata = s_q.now.second;
            OFS_MIN:  bus_rdata = s_q.now.minute;
            OFS_HOUR: bus_rdata = s_q.now.hour;
            OFS_DAY:  bus_rdata = s_q.now.day;
            OFS_MON:  bus_rdata = s_q.now.month;
            OFS_YEAR: bus_rdata = s_q.now.year;
            OFS_WDAY: bus_rdata = s_q.now.wday;
            ALM_SEC:  bus_rdata = s_q.alm.second;
            ALM_MIN:  bus_rdata = s_q.alm.minute;
            ALM_HOUR: bus_rdata = s_q.alm.hour;
            ALM_DAY:  bus_rdata = s_q.alm.day;
            ALM_MON:  bus_rdata = s_q.alm.month;
            ALM_YEAR: bus_rdata = s_q.alm.year;
            OFS_CTRL: bus_rdata = {7'd0, s_q.run};
            OFS_STAT: bus_rdata = {1'b0, s_q.ev, s_q.run, busy};
            OFS_IEN:  bus_rdata = {4'd0, s_q.ie_alarm, s_q.ie_timer, 2'd0};
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign irq = (s_q.ev[4] && s_q.ie_alarm) || (s_q.ev[0] && s_q.ie_timer);

endmodule

// File: rtl/bcd_cal_checker.sv
module bcd_cal_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        time_wr,
    input logic        step,
    input logic        busy,
    input logic        run,
    input logic        wr,
    input logic [7:0]  addr,
    input logic [7:0]  wdata,
    input logic [55:0] now_flat,
    input logic [47:0] alm_flat,
    input logic        alarm_flag,
    input logic        ie_timer,
    input logic        ie_alarm,
    input logic        irq
);
    a_r10_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !time_wr) |=> $stable(now_flat));

    a_r11_no_tick_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !time_wr) |=> $stable(now_flat));

    a_r2_update_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !time_wr) |=> $stable(now_flat));

    a_r7_alarm_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(alarm_flag) && $stable(alm_flat)) |-> (now_flat[47:0] == alm_flat));

    a_r8_alarm_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 8'h44 && wdata[6] && !step) |=> !alarm_flag);

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_timer && !ie_alarm) |-> !irq);

    a_r9_alarm_drives_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && ie_alarm) |-> irq);

endmodule

bind bcd_cal_clock bcd_cal_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .time_wr    (time_wr),
    .step       (step),
    .busy       (busy),
    .run        (s_q.run),
    .wr         (wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .now_flat   (s_q.now),
    .alm_flat   (s_q.alm),
    .alarm_flag (s_q.ev[4]),
    .ie_timer   (s_q.ie_timer),
    .ie_alarm   (s_q.ie_alarm),
    .irq        (irq)
);

// File: tb/bcd_cal_clock_test.sv
`timescale 1ns/1ps
module bcd_cal_clock_test;
    localparam int PRE = 8;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic irq;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    bcd_cal_clock #(.PRESCALE(PRE)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    // packs {wday,year,month,day,hour,min,sec}; returns {dayev,hourev,minev,time}
    function automatic logic [58:0] model_next(input logic [55:0] t);
        int s, mi, h, d, mo, y, wd;
        logic me, he, de;
        s = b2i(t[7:0]); mi = b2i(t[15:8]); h = b2i(t[23:16]); d = b2i(t[31:24]);
        mo = b2i(t[39:32]); y = b2i(t[47:40]); wd = b2i(t[55:48]);
        me = 0; he = 0; de = 0;
        s++;
        if (s == 60) begin s = 0; mi++; me = 1; end
        if (mi == 60) begin mi = 0; h++; he = 1; end
        if (h == 24) begin h = 0; d++; de = 1; wd = (wd + 1) % 7; end
        if (d > mdays(mo, y)) begin d = 1; mo++; end
        if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
        return {de, he, me, i2b(wd), i2b(y), i2b(mo), i2b(d), i2b(h), i2b(mi), i2b(s)};
    endfunction

    task automatic read_time(output logic [55:0] t);
        logic [7:0] b;
        for (int i = 0; i < 7; i++) begin
            bus_read(8'(i * 4), b);
            t[8*i +: 8] = b;
        end
    endtask

    // load a time, an alarm one second ahead (optionally one field nudged), run one update
    task automatic run_case(input logic [55:0] t, input int pert, input bit iet,
                            input bit iea, input string tag);
        logic [58:0] m;
        logic [55:0] got;
        logic [7:0]  st, ab;
        bit          aexp;
        m = model_next(t);
        aexp = (pert < 0);
        bus_write(8'h40, 8'h00);
        bus_write(8'h48, {4'd0, iea, iet, 2'd0});
        for (int i = 0; i < 6; i++) begin
            ab = m[8*i +: 8];
            if (i == pert) ab = ab ^ 8'h01;
            bus_write(8'(8'h20 + i * 4), ab);
        end
        bus_write(8'h44, 8'h7C);
        for (int i = 0; i < 7; i++) bus_write(8'(i * 4), t[8*i +: 8]);
        bus_write(8'h40, 8'h01);
        repeat (PRE) @(negedge clk);
        read_time(got);
        check({"R3 R4 R5 time after update ", tag}, 64'(got), 64'(m[55:0]));
        bus_read(8'h44, st);
        check({"R7 R8 status ", tag}, 64'(st),
              64'({1'b0, aexp, m[58], m[57], m[56], 1'b1, 1'b1, 1'b0}));
        check({"R9 irq ", tag}, 64'(irq), 64'((aexp && iea) || iet));
    endtask

    function automatic logic [55:0] mk(input int wd, y, mo, d, h, mi, s);
        return {i2b(wd), i2b(y), i2b(mo), i2b(d), i2b(h), i2b(mi), i2b(s)};
    endfunction

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [55:0] t, got;
        logic [7:0]  b;
        void'($urandom(32'd4177));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_time(got);
        check("R1 reset time", 64'(got), 64'(56'h00_00_01_01_00_00_00));
        bus_read(8'h40, b); check("R1 reset ctrl", 64'(b), 64'h0);
        bus_read(8'h44, b); check("R1 reset status", 64'(b), 64'h0);
        bus_read(8'h48, b); check("R1 reset ien", 64'(b), 64'h0);
        check("R1 reset irq", 64'(irq), 64'h0);

        // R3 R4 R5 R7 directed boundaries
        run_case(mk(6, 23, 2, 28, 23, 59, 59), -1, 0, 1, "feb common");
        run_case(mk(3, 24, 2, 28, 23, 59, 59), -1, 0, 1, "feb leap 28");
        run_case(mk(4, 24, 2, 29, 23, 59, 59), -1, 1, 0, "feb leap 29");
        run_case(mk(2, 99, 12, 31, 23, 59, 59), -1, 1, 1, "year wrap");
        run_case(mk(0, 45, 4, 30, 23, 59, 59), 3, 0, 1, "april end");
        run_case(mk(5, 10, 1, 31, 23, 59, 59), 5, 0, 1, "jan end");
        run_case(mk(1, 10, 11, 30, 12, 59, 59), 0, 0, 1, "hour carry");
        run_case(mk(1, 10, 7, 15, 12, 30, 59), 4, 0, 1, "year mismatch R7");

        // random cases against the model
        for (int k = 0; k < 40; k++) begin
            int y, mo, d, h, mi, s, p;
            y  = $urandom % 100;
            mo = 1 + $urandom % 12;
            d  = ($urandom % 3 == 0) ? mdays(mo, y) : 1 + $urandom % mdays(mo, y);
            h  = ($urandom % 3 == 0) ? 23 : $urandom % 24;
            mi = ($urandom % 2 == 0) ? 59 : $urandom % 60;
            s  = ($urandom % 2 == 0) ? 59 : $urandom % 60;
            p  = int'($urandom % 7) - 1;
            run_case(mk($urandom % 7, y, mo, d, h, mi, s), p, $urandom % 2, $urandom % 2,
                     "random");
        end

        // R8 write-one-to-clear, with clock frozen (R10)
        run_case(mk(0, 30, 6, 10, 8, 0, 10), -1, 0, 1, "w1c setup");
        bus_write(8'h40, 8'h00);
        bus_write(8'h44, 8'h00);
        bus_read(8'h44, b); check("R8 write zero keeps flags", 64'(b), 64'h44);
        bus_write(8'h44, 8'h04);
        bus_read(8'h44, b); check("R8 clear second flag only", 64'(b), 64'h40);
        check("R9 irq kept by alarm", 64'(irq), 64'h1);
        bus_write(8'h44, 8'h40);
        bus_read(8'h44, b); check("R8 clear alarm flag", 64'(b), 64'h00);
        check("R9 irq drops", 64'(irq), 64'h0);

        // R10 stopped clock holds
        read_time(t);
        repeat (30) @(negedge clk);
        read_time(got);
        check("R10 frozen time", 64'(got), 64'(t));
        bus_read(8'h44, b); check("R10 run bit clear", 64'(b[1:0]), 64'h0);

        // R6 mid-second write restarts the prescaler
        bus_write(8'h40, 8'h01);
        repeat (3) @(negedge clk);
        bus_write(8'h00, 8'h30);
        repeat (PRE - 1) @(negedge clk);
        bus_read(8'h00, b); check("R6 no update before full second", 64'(b), 64'h30);
        bus_read(8'h44, b); check("R2 busy before update", 64'(b[0]), 64'h1);
        @(negedge clk);
        bus_read(8'h00, b); check("R6 update one second after write", 64'(b), 64'h31);
        bus_read(8'h44, b); check("R2 busy low after update", 64'(b[0]), 64'h0);

        // R11 no ticks, no counting
        tick = 1'b0;
        bus_write(8'h00, 8'h10);
        repeat (40) @(negedge clk);
        bus_read(8'h00, b); check("R11 held without ticks", 64'(b), 64'h10);
        bus_read(8'h44, b); check("R11 not busy without ticks", 64'(b[0]), 64'h0);
        tick = 1'b1;
        repeat (PRE) @(negedge clk);
        bus_read(8'h00, b); check("R11 counts resumed ticks", 64'(b), 64'h11);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule